// File: doc/BRIEF.md
# Keyed Watchdog and Reset Generator

This block pairs a watchdog counter with a reset pulse generator that merges three request sources into one internal reset output. Software keeps the watchdog alive by writing a two-byte restart key to a key register; a second two-byte key asks for a software reset, and any other byte pair is treated as a fault that resets at once. A compare-match request from a neighbouring counter unit gives a shorter internal pulse.

Long pulses (watchdog expiry, software key and fault) may also appear on a pin-level reset output whose polarity is selectable and which can be switched off. Short compare-match pulses never reach the pin. Two sticky cause flags record why a reset happened; they are held across the reset they describe and clear only on an explicit write of zero or on power-on reset. When a new request lands on an active pulse, the pulse continues for whichever is longer: its own remaining time or the new length.

Top module: `kwd_reset_gen`

## Requirements
- R1: After power-on reset, int_rst is 0, pin_rst is 1 (enabled and active-low), and both flags are 0.
- R2: With tmo_limit = N > 0, int_rst rises on the N-th clock edge after the last restart. It stays high for exactly 49 cycles and sets flag_wdt only.
- R3: Two writes to address 0 with the bytes 1Eh and then E1h restart the watchdog count. They give no pulse and change no flag.
- R4: Two writes to address 0 with the bytes 5Ah and then A5h start a 49-cycle pulse in the cycle after the second write and set flag_sw.
- R5: After a valid first byte (1Eh or 5Ah), a next key byte that does not complete the same key starts a 49-cycle pulse and sets both flags.
- R6: A first key byte other than 1Eh or 5Ah starts a 49-cycle pulse at once and sets both flags.
- R7: A cmp_match cycle starts a 16-cycle pulse that never drives the pin and sets no flag.
- R8: The flags are sticky. A write to address 1 with data bit 7 = 0 clears flag_wdt, and data bit 6 = 0 clears flag_sw. A 1 in either bit leaves that flag unchanged, and a new cause in the same cycle wins over the clear.
- R9: A write to address 1 with bit 0 = 1 keeps pin_rst at its idle level during every pulse.
- R10: Address 1 bit 1 selects pin polarity: 0 gives active-low (idle 1), and 1 gives active-high (idle 0).
- R11: A request during an active pulse sets the remaining length to the larger of the remaining cycles and the new length. Once a long source joins a pulse, the pin stays driven until that pulse ends.
- R12: tmo_limit = 0 disables watchdog expiry.
- R13: The watchdog count is held at zero during any pulse and starts again from zero when the pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the key register, 1 selects the control/flag register |
| wr_data | input | 8 | Write byte |
| tmo_limit | input | CNT_W | Watchdog period in cycles; 0 disables expiry |
| cmp_match | input | 1 | Compare-match reset request |
| int_rst | output | 1 | Internal reset pulse, active high |
| pin_rst | output | 1 | Pin-level reset with selectable polarity |
| flag_wdt | output | 1 | Sticky watchdog-expiry cause flag |
| flag_sw | output | 1 | Sticky software-reset cause flag |

## Verification
The key decoder is driven with every pairing of the two valid first bytes against matching, crossed and repeated second bytes, plus an invalid first byte and a key interrupted by the other key's first byte. Together these separate restart, software reset and the two kinds of fault. Expiry is timed from a restart and from the end of a pulse, with a restart just before the limit and with the limit at zero, so an off-by-one in the count shows up. Overlap cases put a short request late in a long pulse and a long request inside a short one, and pin checks under both polarities and with the pin disabled show which sources reach the pin.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
   localparam int unsigned BYTE_W = 8;
   typedef enum logic [1:0] {KS_IDLE, KS_KICK, KS_SOFT} key_state_e;
endpackage

// File: rtl/kwd_key_seq.sv
module kwd_key_seq
   import kwd_pkg::*;
#(
   parameter logic [BYTE_W-1:0] KICK_A = 8'h1E,
   parameter logic [BYTE_W-1:0] KICK_B = 8'hE1,
   parameter logic [BYTE_W-1:0] SOFT_A = 8'h5A,
   parameter logic [BYTE_W-1:0] SOFT_B = 8'hA5
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_wr,
   input  logic [BYTE_W-1:0] key_byte,
   output logic              kick,
   output logic              soft_hit,
   output logic              bad_seq,
   output key_state_e        state_o
);
   key_state_e state_q, state_d;

   always_comb begin
      state_d  = state_q;
      kick     = 1'b0;
      soft_hit = 1'b0;
      bad_seq  = 1'b0;
      if (key_wr) begin
         case (state_q)
            KS_IDLE: begin
               if (key_byte == KICK_A)      state_d = KS_KICK;
               else if (key_byte == SOFT_A) state_d = KS_SOFT;
               else                         bad_seq = 1'b1;
            end
            KS_KICK: begin
               state_d = KS_IDLE;
               if (key_byte == KICK_B) kick    = 1'b1;
               else                    bad_seq = 1'b1;
            end
            KS_SOFT: begin
               state_d = KS_IDLE;
               if (key_byte == SOFT_B) soft_hit = 1'b1;
               else                    bad_seq  = 1'b1;
            end
            default: state_d = KS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= KS_IDLE;
      else        state_q <= state_d;
   end

   assign state_o = state_q;
endmodule

// File: rtl/kwd_wdog_cnt.sv
module kwd_wdog_cnt #(
   parameter int unsigned CNT_W = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] limit,
   input  logic             clear,
   input  logic             hold,
   output logic             expire
);
   logic [CNT_W-1:0] cnt_q;
   logic             armed;

   assign armed  = (limit != '0);
   assign expire = armed && !hold && !clear && (cnt_q >= limit - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt_q <= '0;
      else if (clear || hold || expire) cnt_q <= '0;
      else if (armed)                 cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/kwd_pulse_gen.sv
module kwd_pulse_gen #(
   parameter int unsigned LONG_LEN  = 49,
   parameter int unsigned SHORT_LEN = 16
)(
   input  logic clk,
   input  logic rst_n,
   input  logic req_long,
   input  logic req_short,
   output logic pulse,
   output logic pin_src
);
   localparam int unsigned LEN_W = $clog2(LONG_LEN + 1);
   localparam logic [LEN_W-1:0] LONG_V  = LEN_W'(LONG_LEN);
   localparam logic [LEN_W-1:0] SHORT_V = LEN_W'(SHORT_LEN);

   logic [LEN_W-1:0] rem_q, rem_dec, rem_d;
   logic             pin_q;

   always_comb begin
      rem_dec = (rem_q != '0) ? rem_q - 1'b1 : '0;
      rem_d   = rem_dec;
      if (req_short && SHORT_V > rem_d) rem_d = SHORT_V;
      if (req_long  && LONG_V  > rem_d) rem_d = LONG_V;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         pin_q <= 1'b0;
      end else begin
         rem_q <= rem_d;
         if (req_long)          pin_q <= 1'b1;
         else if (rem_d == '0)  pin_q <= 1'b0;
      end
   end

   assign pulse   = (rem_q != '0);
   assign pin_src = pin_q;
endmodule

// File: rtl/kwd_reset_gen.sv
module kwd_reset_gen
   import kwd_pkg::*;
#(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned LONG_LEN  = 49,
   parameter int unsigned SHORT_LEN = 16,
   parameter bit          PIN_REG   = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [CNT_W-1:0]  tmo_limit,
   input  logic              cmp_match,
   output logic              int_rst,
   output logic              pin_rst,
   output logic              flag_wdt,
   output logic              flag_sw
);
   localparam int unsigned BIT_OFF   = 0;
   localparam int unsigned BIT_POL   = 1;
   localparam int unsigned BIT_FSW   = 6;
   localparam int unsigned BIT_FWDT  = 7;

   generate
      if (SHORT_LEN < 1 || LONG_LEN < SHORT_LEN)
         $error("kwd_reset_gen: pulse lengths must satisfy 1 <= SHORT_LEN <= LONG_LEN");
      if (CNT_W < 2)
         $error("kwd_reset_gen: CNT_W must be at least 2");
   endgenerate

   logic       key_wr, ctl_wr;
   logic       kick, soft_hit, bad_seq, expire;
   logic       pin_src, pin_drv;
   logic       ctrl_off, ctrl_pol;
   key_state_e key_state;

   assign key_wr = wr_en && (wr_addr == 1'b0);
   assign ctl_wr = wr_en && (wr_addr == 1'b1);

   kwd_key_seq u_keys (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_wr   (key_wr),
      .key_byte (wr_data),
      .kick     (kick),
      .soft_hit (soft_hit),
      .bad_seq  (bad_seq),
      .state_o  (key_state)
   );

   kwd_wdog_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .limit  (tmo_limit),
      .clear  (kick),
      .hold   (int_rst),
      .expire (expire)
   );

   kwd_pulse_gen #(.LONG_LEN(LONG_LEN), .SHORT_LEN(SHORT_LEN)) u_pulse (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_long  (expire | soft_hit | bad_seq),
      .req_short (cmp_match),
      .pulse     (int_rst),
      .pin_src   (pin_src)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_off <= 1'b0;
         ctrl_pol <= 1'b0;
         flag_wdt <= 1'b0;
         flag_sw  <= 1'b0;
      end else begin
         if (ctl_wr) begin
            ctrl_off <= wr_data[BIT_OFF];
            ctrl_pol <= wr_data[BIT_POL];
         end
         flag_wdt <= ((ctl_wr ? wr_data[BIT_FWDT] : 1'b1) & flag_wdt) | expire | bad_seq;
         flag_sw  <= ((ctl_wr ? wr_data[BIT_FSW]  : 1'b1) & flag_sw)  | soft_hit | bad_seq;
      end
   end

   assign pin_drv = pin_src && !ctrl_off;

   generate
      if (PIN_REG) begin : g_pin_reg
         logic pin_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pin_q <= 1'b1;
            else        pin_q <= ctrl_pol ? pin_drv : ~pin_drv;
         end
         assign pin_rst = pin_q;
      end else begin : g_pin_comb
         assign pin_rst = ctrl_pol ? pin_drv : ~pin_drv;
      end
   endgenerate
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker
   import kwd_pkg::*;
#(
   parameter int unsigned SHORT_LEN = 16
)(
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              wr_addr,
   input logic [BYTE_W-1:0] wr_data,
   input logic              int_rst,
   input logic              pin_rst,
   input logic              flag_wdt,
   input logic              flag_sw,
   input logic              ctrl_off,
   input logic              ctrl_pol,
   input key_state_e        key_state
);
   logic [15:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              run_len <= '0;
      else if (!int_rst)       run_len <= '0;
      else if (run_len != '1)  run_len <= run_len + 1'b1;
   end

   p_bad_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_addr && key_state == KS_IDLE && wr_data != 8'h1E && wr_data != 8'h5A)
      |=> (int_rst && flag_wdt && flag_sw));

   p_wdt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_wdt) |-> $past(wr_en && wr_addr && !wr_data[7]));

   p_sw_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_sw) |-> $past(wr_en && wr_addr && !wr_data[6]));

   p_pin_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_off && $past(ctrl_off) && $stable(ctrl_pol)) |-> (pin_rst == ~ctrl_pol));

   p_pin_needs_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(ctrl_pol) && pin_rst == ctrl_pol) |-> (int_rst || $past(int_rst)));

   p_min_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(int_rst) |-> (run_len >= 16'(SHORT_LEN)));
endmodule

bind kwd_reset_gen kwd_checker #(.SHORT_LEN(SHORT_LEN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .int_rst   (int_rst),
   .pin_rst   (pin_rst),
   .flag_wdt  (flag_wdt),
   .flag_sw   (flag_sw),
   .ctrl_off  (ctrl_off),
   .ctrl_pol  (ctrl_pol),
   .key_state (key_state)
);

// File: tb/kwd_reset_gen_bench.sv
`timescale 1ns/1ps
module kwd_reset_gen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_addr = 1'b0;
   logic [7:0]  wr_data = '0;
   logic [15:0] tmo_limit = '0;
   logic        cmp_match = 1'b0;
   logic        int_rst, pin_rst, flag_wdt, flag_sw;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   kwd_reset_gen u_kwd_reset_gen (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .tmo_limit(tmo_limit), .cmp_match(cmp_match), .int_rst(int_rst), .pin_rst(pin_rst),
      .flag_wdt(flag_wdt), .flag_sw(flag_sw)
   );

   // {first byte, second byte, kind: 0 restart, 1 soft reset, 2 fault}
   localparam logic [17:0] VEC [0:5] = '{
      {8'h1E, 8'hE1, 2'd0},
      {8'h5A, 8'hA5, 2'd1},
      {8'h1E, 8'hA5, 2'd2},
      {8'h5A, 8'hE1, 2'd2},
      {8'h1E, 8'h1E, 2'd2},
      {8'h5A, 8'h5A, 2'd2}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // counts high cycles of int_rst and cycles where the pin is at act_lvl
   task automatic meas(input logic act_lvl, output int n, output int pn);
      n = 0; pn = 0;
      while (int_rst && n < 300) begin
         n++;
         if (pin_rst == act_lvl) pn++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int n, pn;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(int_rst == 1'b0, "R1 int_rst", int_rst, 0);
      chk(pin_rst == 1'b1, "R1 pin_rst", pin_rst, 1);
      chk({flag_wdt, flag_sw} == 2'b00, "R1 flags", {flag_wdt, flag_sw}, 0);

      repeat (100) @(negedge clk);
      chk(int_rst == 1'b0, "R12 limit zero no expiry", int_rst, 0);

      for (int i = 0; i < 6; i++) begin
         logic [7:0] b1, b2;
         logic [1:0] kind;
         {b1, b2, kind} = VEC[i];
         wr(1'b1, 8'h00);
         wr(1'b0, b1);
         chk(int_rst == 1'b0, "R3 R4 R5 first byte no pulse", int_rst, 0);
         wr(1'b0, b2);
         if (kind == 2'd0) begin
            chk(int_rst == 1'b0, "R3 restart no pulse", int_rst, 0);
            chk({flag_wdt, flag_sw} == 2'b00, "R3 flags", {flag_wdt, flag_sw}, 0);
         end else begin
            chk(int_rst == 1'b1, kind == 2'd1 ? "R4 pulse" : "R5 pulse", int_rst, 1);
            chk({flag_wdt, flag_sw} == (kind == 2'd1 ? 2'b01 : 2'b11),
                kind == 2'd1 ? "R4 flags" : "R5 flags",
                {flag_wdt, flag_sw}, kind == 2'd1 ? 1 : 3);
            meas(1'b0, n, pn);
            chk(n == 49, kind == 2'd1 ? "R4 length" : "R5 length", n, 49);
            chk(pn == 49, "R4 R5 pin driven", pn, 49);
         end
      end

      // R6: invalid first byte
      wr(1'b1, 8'h00);
      wr(1'b0, 8'h33);
      chk({flag_wdt, flag_sw} == 2'b11, "R6 flags", {flag_wdt, flag_sw}, 3);
      meas(1'b0, n, pn);
      chk(n == 49, "R6 length", n, 49);

      // R5: key interrupted by other key's first byte
      wr(1'b1, 8'h00);
      wr(1'b0, 8'h1E);
      wr(1'b0, 8'h5A);
      chk({int_rst, flag_wdt, flag_sw} == 3'b111, "R5 interrupted key", {int_rst, flag_wdt, flag_sw}, 7);
      meas(1'b0, n, pn);

      // R7: compare-match pulse
      wr(1'b1, 8'h00);
      @(negedge clk); cmp_match = 1'b1;
      @(negedge clk); cmp_match = 1'b0;
      meas(1'b0, n, pn);
      chk(n == 16, "R7 length", n, 16);
      chk(pn == 0, "R7 pin untouched", pn, 0);
      chk({flag_wdt, flag_sw} == 2'b00, "R7 no flags", {flag_wdt, flag_sw}, 0);

      // R2: timeout after restart
      tmo_limit = 16'd20;
      wr(1'b0, 8'h1E);
      wr(1'b0, 8'hE1);
      repeat (19) @(negedge clk);
      chk(int_rst == 1'b0, "R2 no early expiry", int_rst, 0);
      @(negedge clk);
      chk(int_rst == 1'b1, "R2 expiry on time", int_rst, 1);
      chk({flag_wdt, flag_sw} == 2'b10, "R2 flags", {flag_wdt, flag_sw}, 2);
      meas(1'b0, n, pn);
      chk(n == 49, "R2 length", n, 49);

      // R13: count restarts from zero after pulse
      repeat (19) @(negedge clk);
      chk(int_rst == 1'b0, "R13 held during pulse", int_rst, 0);
      @(negedge clk);
      chk(int_rst == 1'b1, "R13 expiry after pulse", int_rst, 1);
      meas(1'b0, n, pn);

      // R3: restart late in the period defers expiry
      repeat (14) @(negedge clk);
      wr(1'b0, 8'h1E);
      wr(1'b0, 8'hE1);
      repeat (19) @(negedge clk);
      chk(int_rst == 1'b0, "R3 restart defers expiry", int_rst, 0);
      @(negedge clk);
      chk(int_rst == 1'b1, "R3 expiry after restart", int_rst, 1);
      tmo_limit = 16'd0;
      meas(1'b0, n, pn);

      // R8: clear only the named flag, survival across reset
      wr(1'b1, 8'h40);
      chk({flag_wdt, flag_sw} == 2'b00, "R8 clear wdt keep sw", {flag_wdt, flag_sw}, 0);
      wr(1'b0, 8'h5A);
      wr(1'b0, 8'hA5);
      meas(1'b0, n, pn);
      chk(flag_sw == 1'b1, "R8 flag survives pulse", flag_sw, 1);
      wr(1'b1, 8'h40);
      chk(flag_sw == 1'b1, "R8 bit6 one keeps flag", flag_sw, 1);
      wr(1'b1, 8'h00);
      chk(flag_sw == 1'b0, "R8 bit6 zero clears flag", flag_sw, 0);

      // R9: pin disabled
      wr(1'b1, 8'h01);
      wr(1'b0, 8'h5A);
      wr(1'b0, 8'hA5);
      meas(1'b0, n, pn);
      chk(pn == 0, "R9 pin suppressed", pn, 0);
      chk(n == 49, "R9 internal pulse kept", n, 49);

      // R10: active-high pin
      wr(1'b1, 8'h02);
      chk(pin_rst == 1'b0, "R10 idle low", pin_rst, 0);
      wr(1'b0, 8'h5A);
      wr(1'b0, 8'hA5);
      meas(1'b1, n, pn);
      chk(pn == 49, "R10 active high", pn, 49);

      // R11: short request late in a long pulse
      wr(1'b1, 8'h00);
      wr(1'b0, 8'h5A);
      wr(1'b0, 8'hA5);
      repeat (39) @(negedge clk);
      cmp_match = 1'b1;
      @(negedge clk);
      cmp_match = 1'b0;
      meas(1'b0, n, pn);
      chk(n == 16, "R11 extended to short length", n, 16);
      chk(pn == 16, "R11 pin held to end", pn, 16);

      // R11: long request inside a short pulse
      @(negedge clk); cmp_match = 1'b1;
      @(negedge clk); cmp_match = 1'b0;
      wr(1'b0, 8'h5A);
      wr(1'b0, 8'hA5);
      meas(1'b0, n, pn);
      chk(n == 49, "R11 long overrides short", n, 49);
      chk(pn == 49, "R11 pin from long source", pn, 49);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule